// File: doc/BRIEF.md
# Triggered Capture Front-End

This block sits on the acquisition side of a multi-channel logic analyzer, between the channel inputs and a capture memory. A reload counter turns the fixed system clock into a sample strobe, or is skipped altogether so that every clock cycle yields a sample. While armed, each sample is compared against a trigger condition built from the channels and one external trigger line. On a hit, that sample and every later sample, masked by the channel enables, go to a memory write port at rising addresses. Writing stops when the address reaches a full limit or a stop command arrives.

Software programs the trigger condition, channel enables, reload value, bypass and full limit through a small write-only register port. It then pulses arm and polls the status outputs. These are the triggered, memory-available and capturing flags, a duration counter that counts fixed blocks of clock cycles, and a fill level that holds the next free address once capture has ended.

Top module: `capture_frontend`

## Requirements
- R1: With bypass clear, a sample strobe occurs on the first clock edge after arm and then once every reload+1 cycles. The reload value is 100 MHz divided by the wanted rate, minus one.
- R2: With bypass set (bit 0 of register 5), every clock cycle is a sample and the reload value has no effect.
- R3: Only channels whose trigger-mask bit is set take part in the trigger. A channel with its edge bit set needs a change from a value other than its match bit to its match bit, measured against the previous sample since arm. Any other selected channel must equal its match bit. An empty mask triggers on the first sample.
- R4: The two top bits of the trigger mask select the external line. Bit CH_W+1 (35 by default) asks for a rising edge and bit CH_W (34) asks for a falling edge. Each edge needs a previous sample since arm.
- R5: The triggering sample and every later sample each produce one write. Writes go to consecutive addresses starting at 4. The write data is the sample ANDed with the channel enable mask. The write appears on the cycle after the sample edge.
- R6: After the write to address limit-1, the memory-available flag clears and capture ends. The limit resets to the memory depth minus 16.
- R7: The triggered flag sets with the triggering write and clears on arm. The capturing flag is high from arm until stop or full.
- R8: While capturing, the duration output rises by one every MS_CYCLES clock cycles, whatever the bypass and reload settings. It clears on arm and holds once capture ends.
- R9: A stop during capture clears capturing at that edge and blocks all further writes. The fill level then shows one past the last written address (4 if nothing was written). Stop leaves the memory-available flag unchanged.
- R10: The register map is: 0 channel enable, 1 match values, 2 edge mask, 3 trigger mask, 4 reload, 5 bypass, 6 full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | CH_W+2 | Register write data |
| arm_i | input | 1 | Start a new capture (pulse) |
| stop_i | input | 1 | End the running capture (pulse) |
| chan_i | input | CH_W | Channel inputs |
| ext_trig_i | input | 1 | External trigger line |
| mem_we_o | output | 1 | Capture memory write strobe |
| mem_addr_o | output | ADDR_W | Capture memory write address |
| mem_wdata_o | output | CH_W | Masked sample to store |
| triggered_o | output | 1 | Trigger has fired since arm |
| mem_avail_o | output | 1 | Full limit not yet reached |
| capturing_o | output | 1 | Capture in progress |
| duration_o | output | DUR_W | Elapsed capture time in cycle blocks |
| fill_level_o | output | ADDR_W | Next free write address |

## Verification
A bad divider count shows up at the write port within one reload period as a wrong gap between write strobes. A stale previous-sample register shows up on the first few samples after arm as a trigger that fires early or late. An address or limit error shows up either in the first write address or in the final write count and fill level, which the full-run checks compare against limit minus 4. A duration counter tied to the sample strobe instead of the clock shows up within a few tens of cycles when the reload is non-zero.

// File: rtl/capfe_pkg.sv
package capfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_STORE = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam logic [2:0] RA_CHAN_EN = 3'd0;
    localparam logic [2:0] RA_MATCH   = 3'd1;
    localparam logic [2:0] RA_EDGE    = 3'd2;
    localparam logic [2:0] RA_TMASK   = 3'd3;
    localparam logic [2:0] RA_RELOAD  = 3'd4;
    localparam logic [2:0] RA_BYPASS  = 3'd5;
    localparam logic [2:0] RA_LIMIT   = 3'd6;

endpackage

// File: rtl/capfe_cfg.sv
module capfe_cfg
    import capfe_pkg::*;
#(
    parameter int CH_W   = 34,
    parameter int ADDR_W = 14,
    parameter int DIV_W  = 32,
    parameter int GUARD  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [2:0]        addr_i,
    input  logic [CH_W+1:0]   wdata_i,
    output logic [CH_W-1:0]   chan_en_o,
    output logic [CH_W-1:0]   match_o,
    output logic [CH_W-1:0]   edge_o,
    output logic [CH_W+1:0]   tmask_o,
    output logic [DIV_W-1:0]  reload_o,
    output logic              bypass_o,
    output logic [ADDR_W-1:0] limit_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [CH_W-1:0]   en;
        logic [CH_W-1:0]   match;
        logic [CH_W-1:0]   edg;
        logic [CH_W+1:0]   tmask;
        logic [DIV_W-1:0]  reload;
        logic              bypass;
        logic [ADDR_W-1:0] limit;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d = q;
        if (we_i) begin
            unique case (addr_i)
                RA_CHAN_EN: d.en     = wdata_i[CH_W-1:0];
                RA_MATCH:   d.match  = wdata_i[CH_W-1:0];
                RA_EDGE:    d.edg    = wdata_i[CH_W-1:0];
                RA_TMASK:   d.tmask  = wdata_i;
                RA_RELOAD:  d.reload = DIV_W'(wdata_i);
                RA_BYPASS:  d.bypass = wdata_i[0];
                RA_LIMIT:   d.limit  = ADDR_W'(wdata_i);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.en     <= '1;
            q.match  <= '0;
            q.edg    <= '0;
            q.tmask  <= '0;
            q.reload <= '0;
            q.bypass <= 1'b0;
            q.limit  <= ADDR_W'(DEPTH - GUARD);
        end else begin
            q <= d;
        end
    end

    assign chan_en_o = q.en;
    assign match_o   = q.match;
    assign edge_o    = q.edg;
    assign tmask_o   = q.tmask;
    assign reload_o  = q.reload;
    assign bypass_o  = q.bypass;
    assign limit_o   = q.limit;

endmodule

// File: rtl/capfe_div.sv
module capfe_div #(
    parameter int DIV_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             bypass_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t d, q;

    always_comb begin
        d = q;
        if (restart_i || !run_i)
            d.cnt = '0;
        else if (q.cnt == '0)
            d.cnt = reload_i;
        else
            d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q.cnt <= '0;
        else         q <= d;
    end

    assign strobe_o = run_i && !restart_i && (bypass_i || (q.cnt == '0));

    // R1
    div_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_o && !bypass_i && (reload_i != '0)) |=> (!strobe_o || bypass_i));

endmodule

// File: rtl/capfe_trig.sv
module capfe_trig #(
    parameter int CH_W = 34
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            strobe_i,
    input  logic            restart_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            ext_i,
    input  logic [CH_W-1:0] match_i,
    input  logic [CH_W-1:0] edge_i,
    input  logic [CH_W+1:0] tmask_i,
    output logic            hit_o
);
    localparam int RISE_BIT = CH_W + 1;
    localparam int FALL_BIT = CH_W;

    typedef struct packed {
        logic [CH_W-1:0] prev;
        logic            ext;
        logic            valid;
    } hist_t;

    hist_t d, q;

    logic [CH_W-1:0] lvl_ok, edg_ok, pass;
    logic            rise_ok, fall_ok;

    for (genvar i = 0; i < CH_W; i++) begin : g_chan
        assign lvl_ok[i] = (chan_i[i] == match_i[i]);
        assign edg_ok[i] = q.valid && (q.prev[i] != match_i[i]) && lvl_ok[i];
        assign pass[i]   = !tmask_i[i] || (edge_i[i] ? edg_ok[i] : lvl_ok[i]);
    end

    assign rise_ok = !tmask_i[RISE_BIT] || (q.valid && !q.ext && ext_i);
    assign fall_ok = !tmask_i[FALL_BIT] || (q.valid && q.ext && !ext_i);
    assign hit_o   = strobe_i && (&pass) && rise_ok && fall_ok;

    always_comb begin
        d = q;
        if (restart_i) begin
            d.valid = 1'b0;
        end else if (strobe_i) begin
            d.prev  = chan_i;
            d.ext   = ext_i;
            d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.prev  <= '0;
            q.ext   <= 1'b0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R4
    ext_edge_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_o && (tmask_i[RISE_BIT] || tmask_i[FALL_BIT])) |-> (q.ext != ext_i));

endmodule

// File: rtl/capfe_dur.sv
module capfe_dur #(
    parameter int DUR_W     = 32,
    parameter int MS_CYCLES = 100000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    output logic [DUR_W-1:0] dur_o
);
    localparam int TICK_W = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(MS_CYCLES - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [DUR_W-1:0]  dur;
    } dur_t;

    dur_t d, q;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.tick = '0;
            d.dur  = '0;
        end else if (run_i) begin
            if (q.tick == TICK_LAST) begin
                d.tick = '0;
                d.dur  = q.dur + 1'b1;
            end else begin
                d.tick = q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.tick <= '0;
            q.dur  <= '0;
        end else begin
            q <= d;
        end
    end

    assign dur_o = q.dur;

    // R8
    dur_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> ((dur_o == $past(dur_o)) || (dur_o == $past(dur_o) + 1'b1)));

    // R8
    dur_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clear_i) |=> $stable(dur_o));

endmodule

// File: rtl/capture_frontend.sv
module capture_frontend
    import capfe_pkg::*;
#(
    parameter int CH_W      = 34,
    parameter int ADDR_W    = 14,
    parameter int DIV_W     = 32,
    parameter int DUR_W     = 32,
    parameter int MS_CYCLES = 100000,
    parameter int BASE_ADDR = 4,
    parameter int GUARD     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_addr_i,
    input  logic [CH_W+1:0]   cfg_wdata_i,
    input  logic              arm_i,
    input  logic              stop_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              ext_trig_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [CH_W-1:0]   mem_wdata_o,
    output logic              triggered_o,
    output logic              mem_avail_o,
    output logic              capturing_o,
    output logic [DUR_W-1:0]  duration_o,
    output logic [ADDR_W-1:0] fill_level_o
);
    localparam logic [ADDR_W-1:0] START = ADDR_W'(BASE_ADDR);

    logic [CH_W-1:0]   cfg_en, cfg_match, cfg_edge;
    logic [CH_W+1:0]   cfg_tmask;
    logic [DIV_W-1:0]  cfg_reload;
    logic              cfg_bypass;
    logic [ADDR_W-1:0] cfg_limit;
    logic              strobe, hit, capturing;

    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              trig;
        logic              avail;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [CH_W-1:0]   wdata;
    } top_t;

    top_t d, q;

    capfe_cfg #(.CH_W(CH_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .GUARD(GUARD)) u_cfg (
        .clk_i, .rst_ni,
        .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
        .chan_en_o(cfg_en), .match_o(cfg_match), .edge_o(cfg_edge),
        .tmask_o(cfg_tmask), .reload_o(cfg_reload), .bypass_o(cfg_bypass),
        .limit_o(cfg_limit)
    );

    capfe_div #(.DIV_W(DIV_W)) u_div (
        .clk_i, .rst_ni,
        .run_i(capturing), .restart_i(arm_i), .bypass_i(cfg_bypass),
        .reload_i(cfg_reload), .strobe_o(strobe)
    );

    capfe_trig #(.CH_W(CH_W)) u_trig (
        .clk_i, .rst_ni,
        .strobe_i(strobe), .restart_i(arm_i), .chan_i(chan_i), .ext_i(ext_trig_i),
        .match_i(cfg_match), .edge_i(cfg_edge), .tmask_i(cfg_tmask), .hit_o(hit)
    );

    capfe_dur #(.DUR_W(DUR_W), .MS_CYCLES(MS_CYCLES)) u_dur (
        .clk_i, .rst_ni,
        .run_i(capturing), .clear_i(arm_i), .dur_o(duration_o)
    );

    assign capturing = (q.st == ST_ARMED) || (q.st == ST_STORE);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (arm_i) begin
            d.st    = ST_ARMED;
            d.addr  = START;
            d.trig  = 1'b0;
            d.avail = 1'b1;
        end else if (stop_i && capturing) begin
            d.st = ST_DONE;
        end else if (((q.st == ST_ARMED) && hit) || ((q.st == ST_STORE) && strobe)) begin
            d.trig  = 1'b1;
            d.st    = ST_STORE;
            d.we    = 1'b1;
            d.waddr = q.addr;
            d.wdata = chan_i & cfg_en;
            d.addr  = q.addr + 1'b1;
            if (({1'b0, q.addr} + (ADDR_W+1)'(1)) >= {1'b0, cfg_limit}) begin
                d.avail = 1'b0;
                d.st    = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st    <= ST_IDLE;
            q.addr  <= '0;
            q.trig  <= 1'b0;
            q.avail <= 1'b1;
            q.we    <= 1'b0;
            q.waddr <= '0;
            q.wdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we_o     = q.we;
    assign mem_addr_o   = q.waddr;
    assign mem_wdata_o  = q.wdata;
    assign triggered_o  = q.trig;
    assign mem_avail_o  = q.avail;
    assign capturing_o  = capturing;
    assign fill_level_o = q.addr;

    // R5
    wr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> ($past(capturing) && (mem_addr_o >= START)));

    // R6
    full_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_avail_o) |-> !capturing_o);

    // R7
    trig_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(triggered_o) |-> ($past(capturing) && mem_we_o));

    // R9
    stop_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !arm_i && capturing) |=> (!capturing_o && !mem_we_o && $stable(mem_avail_o)));

endmodule

// File: tb/test_capture_frontend.sv
module test_capture_frontend;
    localparam int CH_W   = 34;
    localparam int ADDR_W = 6;
    localparam int DIV_W  = 8;
    localparam int DUR_W  = 16;
    localparam int MS     = 10;
    localparam int CFG_W  = CH_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              arm = 1'b0;
    logic              stop = 1'b0;
    logic [CH_W-1:0]   chan = '0;
    logic              ext = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [CH_W-1:0]   mem_wdata;
    logic              triggered, mem_avail, capturing;
    logic [DUR_W-1:0]  duration;
    logic [ADDR_W-1:0] fill_level;

    always #10 clk = ~clk;

    capture_frontend #(
        .CH_W(CH_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DUR_W(DUR_W),
        .MS_CYCLES(MS), .BASE_ADDR(4), .GUARD(16)
    ) i_capture_frontend (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .arm_i(arm), .stop_i(stop), .chan_i(chan), .ext_trig_i(ext),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .triggered_o(triggered), .mem_avail_o(mem_avail), .capturing_o(capturing),
        .duration_o(duration), .fill_level_o(fill_level)
    );

    int n_chk = 0;
    int n_fail = 0;
    int rel = 0;
    int wr_cnt = 0;
    int first_idx = 0;
    int last_idx = 0;
    logic [ADDR_W-1:0] last_addr = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        rel++;
        if (mem_we) begin
            wr_cnt++;
            if (wr_cnt == 1) first_idx = rel;
            last_idx  = rel;
            last_addr = mem_addr;
        end
    endtask

    task automatic wcfg(input logic [2:0] a, input logic [CFG_W-1:0] v);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic arm_now();
        arm = 1'b1;
        tick();
        arm = 1'b0;
        rel = 0; wr_cnt = 0; first_idx = 0; last_idx = 0;
    endtask

    task automatic stop_now();
        stop = 1'b1;
        tick();
        stop = 1'b0;
    endtask

    task automatic feed(input string req, input logic [CH_W-1:0] c, input logic e, input logic exp_we);
        chan = c; ext = e;
        tick();
        chk(req, 64'(mem_we), 64'(exp_we));
    endtask

    task automatic set_trig(input logic [CFG_W-1:0] m, input logic [CFG_W-1:0] eg, input logic [CFG_W-1:0] tm);
        wcfg(3'd1, m);
        wcfg(3'd2, eg);
        wcfg(3'd3, tm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 200000 cycles expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 R6 R8 reset state
        chk("R7 reset capturing", 64'(capturing), 64'd0);
        chk("R7 reset triggered", 64'(triggered), 64'd0);
        chk("R6 reset mem_avail", 64'(mem_avail), 64'd1);
        chk("R5 reset mem_we", 64'(mem_we), 64'd0);
        chk("R8 reset duration", 64'(duration), 64'd0);
        chk("R9 reset fill", 64'(fill_level), 64'd0);

        // R1 divider sweep, empty trigger mask (R10 reg 4 reload, reg 5 bypass)
        for (int r = 0; r < 7; r++) begin
            wcfg(3'd4, CFG_W'(r));
            wcfg(3'd5, '0);
            arm_now();
            repeat (4 * (r + 1)) tick();
            chk("R1 write count", 64'(wr_cnt), 64'd4);
            chk("R1 first strobe", 64'(first_idx), 64'd1);
            chk("R1 strobe spacing", 64'(last_idx - first_idx), 64'(3 * (r + 1)));
            chk("R5 last address", 64'(last_addr), 64'd7);
            stop_now();
        end

        // R2 bypass ignores reload
        wcfg(3'd4, CFG_W'(5));
        wcfg(3'd5, CFG_W'(1));
        arm_now();
        repeat (4) tick();
        chk("R2 bypass count", 64'(wr_cnt), 64'd4);
        chk("R2 bypass last", 64'(last_idx), 64'd4);
        stop_now();

        // R3 level trigger on channel 3, channel 7 unmasked
        set_trig(CFG_W'(8), '0, CFG_W'(8));
        chan = '0; arm_now();
        feed("R3 level noise", CH_W'('h80), 1'b0, 1'b0);
        feed("R3 level low", CH_W'(0), 1'b0, 1'b0);
        chk("R7 not yet triggered", 64'(triggered), 64'd0);
        feed("R3 level hit", CH_W'('h88), 1'b0, 1'b1);
        chk("R5 level data", 64'(mem_wdata), 64'h88);
        chk("R5 level addr", 64'(mem_addr), 64'd4);
        chk("R7 triggered set", 64'(triggered), 64'd1);
        stop_now();

        // R3 rising edge on channel 3
        set_trig(CFG_W'(8), CFG_W'(8), CFG_W'(8));
        chan = CH_W'(8); arm_now();
        feed("R3 edge no history", CH_W'(8), 1'b0, 1'b0);
        feed("R3 edge steady", CH_W'(8), 1'b0, 1'b0);
        feed("R3 edge low", CH_W'(0), 1'b0, 1'b0);
        feed("R3 edge rise", CH_W'(8), 1'b0, 1'b1);
        stop_now();

        // R3 falling edge on channel 3 (match 0)
        set_trig('0, CFG_W'(8), CFG_W'(8));
        chan = '0; arm_now();
        feed("R3 fall no history", CH_W'(0), 1'b0, 1'b0);
        feed("R3 fall high", CH_W'(8), 1'b0, 1'b0);
        feed("R3 fall hit", CH_W'(0), 1'b0, 1'b1);
        stop_now();

        // R4 external rising edge (bit 35)
        set_trig('0, '0, CFG_W'(1) << 35);
        chan = '0; ext = 1'b1; arm_now();
        feed("R4 rise no history", CH_W'(0), 1'b1, 1'b0);
        feed("R4 rise steady", CH_W'(0), 1'b1, 1'b0);
        feed("R4 rise low", CH_W'(0), 1'b0, 1'b0);
        feed("R4 rise hit", CH_W'(0), 1'b1, 1'b1);
        stop_now();

        // R4 external falling edge (bit 34)
        set_trig('0, '0, CFG_W'(1) << 34);
        ext = 1'b0; arm_now();
        feed("R4 fall low", CH_W'(0), 1'b0, 1'b0);
        feed("R4 fall high", CH_W'(0), 1'b1, 1'b0);
        feed("R4 fall hit", CH_W'(0), 1'b0, 1'b1);
        stop_now();

        // R3 combined level bit0 and rising edge bit1
        set_trig(CFG_W'(3), CFG_W'(2), CFG_W'(3));
        chan = '0; ext = 1'b0; arm_now();
        feed("R3 combo idle", CH_W'(0), 1'b0, 1'b0);
        feed("R3 combo edge only", CH_W'(2), 1'b0, 1'b0);
        feed("R3 combo back", CH_W'(0), 1'b0, 1'b0);
        feed("R3 combo level only", CH_W'(1), 1'b0, 1'b0);
        feed("R3 combo both", CH_W'(3), 1'b0, 1'b1);
        feed("R5 store follows", CH_W'(0), 1'b0, 1'b1);
        chk("R5 store addr", 64'(mem_addr), 64'd5);
        stop_now();

        // R5 masked data sweep, empty mask triggers at once
        set_trig('0, '0, '0);
        wcfg(3'd0, CFG_W'(34'h2_F0F0_3C3C));
        arm_now();
        for (int k = 0; k < 8; k++) begin
            logic [CH_W-1:0] p;
            p = CH_W'(64'(k + 1) * 64'h1_9E37_79B9);
            feed("R5 data write", p, 1'b0, 1'b1);
            chk("R5 data mask", 64'(mem_wdata), 64'(p & 34'h2_F0F0_3C3C));
            chk("R5 data addr", 64'(mem_addr), 64'(4 + k));
        end
        stop_now();
        wcfg(3'd0, '1);

        // R6 full at default limit 48
        arm_now();
        chk("R6 avail after arm", 64'(mem_avail), 64'd1);
        chk("R7 capturing after arm", 64'(capturing), 64'd1);
        repeat (60) tick();
        chk("R6 full count", 64'(wr_cnt), 64'd44);
        chk("R6 full last addr", 64'(last_addr), 64'd47);
        chk("R6 full avail", 64'(mem_avail), 64'd0);
        chk("R6 full capturing", 64'(capturing), 64'd0);
        chk("R6 full fill", 64'(fill_level), 64'd48);

        // R6 programmed limit 10
        wcfg(3'd6, CFG_W'(10));
        arm_now();
        chk("R6 avail rearm", 64'(mem_avail), 64'd1);
        repeat (20) tick();
        chk("R6 small count", 64'(wr_cnt), 64'd6);
        chk("R6 small last", 64'(last_addr), 64'd9);
        chk("R6 small fill", 64'(fill_level), 64'd10);
        chk("R6 small avail", 64'(mem_avail), 64'd0);
        wcfg(3'd6, CFG_W'(48));

        // R9 stop while waiting for trigger
        set_trig(CFG_W'(1), '0, CFG_W'(1));
        chan = '0; arm_now();
        repeat (3) tick();
        stop_now();
        chk("R9 stop armed capturing", 64'(capturing), 64'd0);
        chk("R9 stop armed triggered", 64'(triggered), 64'd0);
        chk("R9 stop armed fill", 64'(fill_level), 64'd4);
        chk("R9 stop armed avail", 64'(mem_avail), 64'd1);
        chan = CH_W'(1);
        repeat (5) tick();
        chk("R9 no writes after stop", 64'(wr_cnt), 64'd0);

        // R9 stop while storing
        set_trig('0, '0, '0);
        chan = '0; arm_now();
        repeat (5) tick();
        stop_now();
        chk("R9 stop store count", 64'(wr_cnt), 64'd5);
        chk("R9 stop store fill", 64'(fill_level), 64'd9);
        chk("R9 stop store capturing", 64'(capturing), 64'd0);
        chk("R9 stop store avail", 64'(mem_avail), 64'd1);
        chk("R7 triggered kept", 64'(triggered), 64'd1);
        repeat (5) tick();
        chk("R9 store frozen", 64'(wr_cnt), 64'd5);

        // R8 duration with and without bypass, reload 7
        set_trig(CFG_W'(1), '0, CFG_W'(1));
        chan = '0;
        for (int b = 0; b < 2; b++) begin
            wcfg(3'd4, CFG_W'(7));
            wcfg(3'd5, CFG_W'(b));
            arm_now();
            chk("R8 cleared on arm", 64'(duration), 64'd0);
            repeat (25) tick();
            chk("R8 after 25", 64'(duration), 64'd2);
            repeat (5) tick();
            chk("R8 after 30", 64'(duration), 64'd3);
            stop_now();
            repeat (20) tick();
            chk("R8 held after stop", 64'(duration), 64'd3);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule